// File: doc/BRIEF.md
# Strobed Serial Command Decoder

This block is the host-facing serial slave of a segment display controller. A host frames each transfer by raising a strobe line. It toggles a shift clock and moves bytes most significant bit first on a single data line. Inside a frame the first complete byte is a command. The command picks one of four classes: display mode, data routing, address, or status. Every later byte in the same frame is data. Data goes to the display RAM, the character RAM, the character-generator RAM or the LED latch, according to the routing chosen earlier. When key readback is selected, the block instead shifts key bytes back out over the same line, which it can only pull low.

The serial inputs are sampled on the system clock. A shift clock edge is found by comparing the current sample with the one taken on the previous cycle, so each level of the shift clock must last at least two system clock cycles. Write data leaves the block as single-cycle pulses on one write port, and the target is given by a select field. The sinks are plain RAMs and must take every pulse: the port has no back-pressure, and a write is never held or repeated. Key bytes come in on a combinational read port. The block drives the byte index, and the key source returns the byte in the same cycle.

Top module: `serial_cmd_decoder`

## Requirements
- R1: While `stb` is high, bits on `sdi` are captured on each rising `sck` edge, most significant bit first. Eight rising edges form one byte. The byte's effect shows on the outputs one system clock after the cycle in which the eighth rising edge is first seen.
- R2: The first complete byte after `stb` rises is a command, and every later byte in that frame is data. If `stb` drops part way through a byte, that byte is discarded with no effect, and bytes already completed keep their effect.
- R3: Bits 7:6 of a command choose its class: 00 display mode, 01 data routing, 10 address, 11 status.
- R4: A status command loads `lcd_mode` from bits 1:0, `led_en` from bit 2, `scan_en` from bit 3, `standby` from bit 4 and `test_mode` from bit 5.
- R5: A display-mode command takes `duty_15` from bit 0, `slave` from bit 1 and `drive_int` from bit 2. If these three bits differ from the stored ones, the command also sets `lcd_mode` to 00, `led_en` to 1 and `scan_en` to 0. If they are equal, the command changes nothing.
- R6: A data-routing command takes its target from bits 2:0: 000 display RAM, 001 character RAM, 010 generator RAM, 011 LED latch, 100 key read. Codes 101 to 111 make data bytes do nothing. A data byte for one of the three RAMs gives a one-cycle `wr_en` pulse, with `wr_sel` equal to the target code, `wr_addr` equal to the held address and `wr_data` equal to the byte.
- R7: If bit 3 of the data-routing command is 0, the address goes up by one after each display RAM or character RAM write. If bit 3 is 1, the address stays fixed. A generator RAM write never changes the address, because the address there is a character code.
- R8: An address command loads bits 4:0. A write happens only while the held address is within the current target's range: 0 to 24 for display RAM, 0 to 7 for character RAM, 0 to 15 for generator RAM. Out of range, bytes are dropped and the address does not move. If an increment takes the address past the last location, further writes are blocked until a new address is set.
- R9: A generator RAM data byte carries a row number in bits 7:5 and dots in bits 4:0. A byte with row 7 is dropped.
- R10: A data byte for the LED latch loads its low four bits into `led_latch`, where a 1 means that LED is lit. The upper bits are ignored and no `wr_en` pulse is produced.
- R11: After a key-read routing command, each falling `sck` edge in that frame puts out the next key bit, most significant bit first, starting with bit 7 of byte 0. `sdo_pull` is 1 exactly when the bit is 0 and `stb` is high. `key_idx` moves to the next byte after every eighth bit and wraps from 3 back to 0.
- R12: When `rst_n` goes low, every mode bit, the routing target, the address, the LED latch and `key_idx` return to 0, and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb | input | 1 | Frame strobe, high while a transfer is open |
| sck | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| sdo_pull | output | 1 | 1 pulls the shared data line low |
| wr_en | output | 1 | One-cycle write pulse |
| wr_sel | output | 2 | Write target: 0 display RAM, 1 character RAM, 2 generator RAM |
| wr_addr | output | ADDR_W | Write address or character code |
| wr_data | output | 8 | Write data byte |
| led_latch | output | LED_W | LED on bits |
| key_idx | output | KEY_IDX_W | Index of the key byte being read |
| key_byte | input | 8 | Key byte at `key_idx` |
| duty_15 | output | 1 | 1 selects the two-line duty |
| slave | output | 1 | 1 selects slave timing |
| drive_int | output | 1 | 1 selects the internal drive supply |
| lcd_mode | output | 2 | 00 off low, 01 off unselected, 1x normal |
| led_en | output | 1 | LED enable |
| scan_en | output | 1 | Key scan enable |
| standby | output | 1 | Standby request |
| test_mode | output | 1 | Test mode |

## Verification
A wrong bit counter or a wrong command flag misaligns every byte that follows. Such a fault shows on the mode outputs or on `wr_addr` and `wr_data` one clock after the next eighth rising edge. A stale or wrongly stepped address shows on `wr_addr` at the next write pulse. A wrong range limit shows as a write pulse that appears or goes missing at the boundary address. Key readback faults show on `sdo_pull` within one system clock of the falling edge that should have produced the bit. A wrong byte index is seen by the ninth falling edge.

// File: rtl/scd_pkg.sv
package scd_pkg;
  typedef enum logic [1:0] {
    CLS_DISP = 2'b00,
    CLS_ROUTE = 2'b01,
    CLS_ADDR = 2'b10,
    CLS_STAT = 2'b11
  } cmd_cls_e;

  localparam logic [2:0] TGT_DRAM  = 3'd0;
  localparam logic [2:0] TGT_CRAM  = 3'd1;
  localparam logic [2:0] TGT_GRAM  = 3'd2;
  localparam logic [2:0] TGT_LED   = 3'd3;
  localparam logic [2:0] TGT_KEY   = 3'd4;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/scd_rx.sv
module scd_rx
  import scd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              sck,
  input  logic              sdi,
  output logic              sck_fall,
  output logic              byte_vld,
  output logic              byte_cmd,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_q;
  logic              first_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              sck_rise;

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      first_q  <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= '0;
      byte_vld <= 1'b0;
      byte_cmd <= 1'b0;
      byte_q   <= '0;
    end else begin
      sck_q    <= sck;
      byte_vld <= 1'b0;
      if (!stb) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (sck_rise) begin
        sh_q  <= {sh_q[BYTE_W-2:0], sdi};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
          byte_vld <= 1'b1;
          byte_cmd <= first_q;
          byte_q   <= {sh_q[BYTE_W-2:0], sdi};
          first_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/scd_ctrl.sv
module scd_ctrl
  import scd_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DD_LAST  = 24,
  parameter int CHR_LAST = 7,
  parameter int CG_LAST  = 15,
  parameter int LED_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              byte_cmd,
  input  logic [BYTE_W-1:0] byte_q,
  output logic              key_start,
  output logic              wr_en,
  output logic [1:0]        wr_sel,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [LED_W-1:0]  led_latch,
  output logic              duty_15,
  output logic              slave,
  output logic              drive_int,
  output logic [1:0]        lcd_mode,
  output logic              led_en,
  output logic              scan_en,
  output logic              standby,
  output logic              test_mode
);
  localparam logic [ADDR_W-1:0] DD_MAX  = ADDR_W'(DD_LAST);
  localparam logic [ADDR_W-1:0] CHR_MAX = ADDR_W'(CHR_LAST);
  localparam logic [ADDR_W-1:0] CG_MAX  = ADDR_W'(CG_LAST);

  logic [2:0]        tgt_q;
  logic              fixed_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_ok;
  logic              bump;
  cmd_cls_e          cls;

  assign cls = cmd_cls_e'(byte_q[7:6]);

  always_comb begin
    case (tgt_q)
      TGT_DRAM: wr_ok = (addr_q <= DD_MAX);
      TGT_CRAM: wr_ok = (addr_q <= CHR_MAX);
      TGT_GRAM: wr_ok = (addr_q <= CG_MAX) && (byte_q[7:5] != 3'd7);
      default:  wr_ok = 1'b0;
    endcase
  end

  assign bump      = !fixed_q && (tgt_q != TGT_GRAM);
  assign key_start = byte_vld && byte_cmd && (cls == CLS_ROUTE) && (byte_q[2:0] == TGT_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q     <= TGT_DRAM;
      fixed_q   <= 1'b0;
      addr_q    <= '0;
      wr_en     <= 1'b0;
      wr_sel    <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      led_latch <= '0;
      duty_15   <= 1'b0;
      slave     <= 1'b0;
      drive_int <= 1'b0;
      lcd_mode  <= 2'b00;
      led_en    <= 1'b0;
      scan_en   <= 1'b0;
      standby   <= 1'b0;
      test_mode <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (byte_vld && byte_cmd) begin
        case (cls)
          CLS_DISP: begin
            if (byte_q[2:0] != {drive_int, slave, duty_15}) begin
              duty_15   <= byte_q[0];
              slave     <= byte_q[1];
              drive_int <= byte_q[2];
              lcd_mode  <= 2'b00;
              led_en    <= 1'b1;
              scan_en   <= 1'b0;
            end
          end
          CLS_ROUTE: begin
            tgt_q   <= byte_q[2:0];
            fixed_q <= byte_q[3];
          end
          CLS_ADDR: addr_q <= byte_q[ADDR_W-1:0];
          CLS_STAT: {test_mode, standby, scan_en, led_en, lcd_mode} <= byte_q[5:0];
          default: ;
        endcase
      end else if (byte_vld) begin
        if (tgt_q == TGT_LED) begin
          led_latch <= byte_q[LED_W-1:0];
        end else if (wr_ok) begin
          wr_en   <= 1'b1;
          wr_sel  <= tgt_q[1:0];
          wr_addr <= addr_q;
          wr_data <= byte_q;
          if (bump) addr_q <= addr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scd_keytx.sv
module scd_keytx
  import scd_pkg::*;
#(
  parameter int KEY_BYTES = 4,
  localparam int KEY_IDX_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic                 sck_fall,
  input  logic                 key_start,
  input  logic [BYTE_W-1:0]    key_byte,
  output logic [KEY_IDX_W-1:0] key_idx,
  output logic                 sdo_pull
);
  localparam int PH_W = $clog2(BYTE_W);

  logic              active_q;
  logic              bit_q;
  logic [PH_W-1:0]   ph_q;
  logic [BYTE_W-1:0] sh_q;

  assign sdo_pull = active_q & stb & ~bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bit_q    <= 1'b1;
      ph_q     <= '0;
      sh_q     <= '0;
      key_idx  <= '0;
    end else if (!stb) begin
      active_q <= 1'b0;
      bit_q    <= 1'b1;
    end else if (key_start) begin
      active_q <= 1'b1;
      bit_q    <= 1'b1;
      ph_q     <= '0;
      key_idx  <= '0;
    end else if (active_q && sck_fall) begin
      if (ph_q == '0) begin
        bit_q <= key_byte[BYTE_W-1];
        sh_q  <= {key_byte[BYTE_W-2:0], 1'b0};
      end else begin
        bit_q <= sh_q[BYTE_W-1];
        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      end
      ph_q <= ph_q + 1'b1;
      if (ph_q == PH_W'(BYTE_W - 1)) begin
        if (key_idx == KEY_IDX_W'(KEY_BYTES - 1)) key_idx <= '0;
        else key_idx <= key_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
  import scd_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DD_LAST   = 24,
  parameter int CHR_LAST  = 7,
  parameter int CG_LAST   = 15,
  parameter int LED_W     = 4,
  parameter int KEY_BYTES = 4,
  localparam int KEY_IDX_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic                 sck,
  input  logic                 sdi,
  output logic                 sdo_pull,
  output logic                 wr_en,
  output logic [1:0]           wr_sel,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [7:0]           wr_data,
  output logic [LED_W-1:0]     led_latch,
  output logic [KEY_IDX_W-1:0] key_idx,
  input  logic [7:0]           key_byte,
  output logic                 duty_15,
  output logic                 slave,
  output logic                 drive_int,
  output logic [1:0]           lcd_mode,
  output logic                 led_en,
  output logic                 scan_en,
  output logic                 standby,
  output logic                 test_mode
);
  logic              sck_fall;
  logic              byte_vld;
  logic              byte_cmd;
  logic [BYTE_W-1:0] byte_q;
  logic              key_start;

  scd_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .sck      (sck),
    .sdi      (sdi),
    .sck_fall (sck_fall),
    .byte_vld (byte_vld),
    .byte_cmd (byte_cmd),
    .byte_q   (byte_q)
  );

  scd_ctrl #(
    .ADDR_W   (ADDR_W),
    .DD_LAST  (DD_LAST),
    .CHR_LAST (CHR_LAST),
    .CG_LAST  (CG_LAST),
    .LED_W    (LED_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_cmd  (byte_cmd),
    .byte_q    (byte_q),
    .key_start (key_start),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .led_latch (led_latch),
    .duty_15   (duty_15),
    .slave     (slave),
    .drive_int (drive_int),
    .lcd_mode  (lcd_mode),
    .led_en    (led_en),
    .scan_en   (scan_en),
    .standby   (standby),
    .test_mode (test_mode)
  );

  scd_keytx #(
    .KEY_BYTES (KEY_BYTES)
  ) u_keytx (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .sck_fall  (sck_fall),
    .key_start (key_start),
    .key_byte  (key_byte),
    .key_idx   (key_idx),
    .sdo_pull  (sdo_pull)
  );
endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
  parameter int ADDR_W   = 5,
  parameter int DD_LAST  = 24,
  parameter int CHR_LAST = 7,
  parameter int CG_LAST  = 15,
  parameter int LED_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb,
  input logic              byte_vld,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [LED_W-1:0]  led_latch,
  input logic [1:0]        lcd_mode,
  input logic              led_en,
  input logic              scan_en,
  input logic              standby,
  input logic              test_mode,
  input logic              duty_15,
  input logic              slave,
  input logic              drive_int
);
  // R2: a write pulse traces back to a byte completed while the strobe was high
  a_r2_write_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(stb, 2));

  // R6: each data byte yields a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R8: no write leaves the range of its target
  a_r8_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_sel == 2'd0) ? (int'(wr_addr) <= DD_LAST) :
               (wr_sel == 2'd1) ? (int'(wr_addr) <= CHR_LAST) :
               (wr_sel == 2'd2) ? (int'(wr_addr) <= CG_LAST) : 1'b0));

  // R9: generator RAM never receives row 7
  a_r9_no_row7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |-> (wr_data[7:5] != 3'd7));

  // R3: mode bits move only in the cycle after a completed byte
  a_r3_modes_follow_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_vld) |-> $stable({lcd_mode, led_en, scan_en, standby, test_mode,
                                  duty_15, slave, drive_int}));

  // R10: the LED latch moves only in the cycle after a completed byte
  a_r10_led_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_vld) |-> $stable(led_latch));
endmodule

bind serial_cmd_decoder scd_checker #(
  .ADDR_W   (ADDR_W),
  .DD_LAST  (DD_LAST),
  .CHR_LAST (CHR_LAST),
  .CG_LAST  (CG_LAST),
  .LED_W    (LED_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stb       (stb),
  .byte_vld  (byte_vld),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .led_latch (led_latch),
  .lcd_mode  (lcd_mode),
  .led_en    (led_en),
  .scan_en   (scan_en),
  .standby   (standby),
  .test_mode (test_mode),
  .duty_15   (duty_15),
  .slave     (slave),
  .drive_int (drive_int)
);

// File: tb/serial_cmd_decoder_tb.sv
module serial_cmd_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0;
  logic       sck = 1'b1;
  logic       sdi = 1'b0;
  logic       sdo_pull;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] led_latch;
  logic [1:0] key_idx;
  logic [7:0] key_byte;
  logic       duty_15, slave, drive_int, led_en, scan_en, standby, test_mode;
  logic [1:0] lcd_mode;

  logic [7:0] key_mem [4];
  assign key_byte = key_mem[key_idx];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sck(sck), .sdi(sdi),
    .sdo_pull(sdo_pull), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .led_latch(led_latch), .key_idx(key_idx),
    .key_byte(key_byte), .duty_15(duty_15), .slave(slave),
    .drive_int(drive_int), .lcd_mode(lcd_mode), .led_en(led_en),
    .scan_en(scan_en), .standby(standby), .test_mode(test_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising clock
  bit [7:0] m_sh, m_pb;
  int       m_cnt;
  bit       m_first, m_pv, m_pc, m_psck;
  bit       m_duty, m_slave, m_drv, m_leden, m_scan, m_stby, m_test;
  bit [1:0] m_lcd;
  int       m_tgt, m_addr, m_wsel, m_waddr;
  bit       m_fix, m_we;
  bit [3:0] m_led;
  bit [7:0] m_wdata;
  bit       m_act, m_cur;
  int       m_ph, m_idx;
  bit [7:0] m_osh;

  function automatic int lim(input int t);
    case (t)
      0: return 24;
      1: return 7;
      2: return 15;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit start;
    bit fall;
    if (!rst_n) begin
      m_sh = 0; m_pb = 0; m_cnt = 0; m_first = 1; m_pv = 0; m_pc = 0; m_psck = 0;
      m_duty = 0; m_slave = 0; m_drv = 0; m_leden = 0; m_scan = 0; m_stby = 0; m_test = 0;
      m_lcd = 0; m_tgt = 0; m_addr = 0; m_fix = 0; m_we = 0; m_led = 0;
      m_wsel = 0; m_waddr = 0; m_wdata = 0;
      m_act = 0; m_cur = 1; m_ph = 0; m_idx = 0; m_osh = 0;
    end else begin
      start = 0;
      fall = m_psck && !sck;
      m_we = 0;
      if (m_pv) begin
        if (m_pc) begin
          case (m_pb[7:6])
            2'b00: if (m_pb[2:0] != {m_drv, m_slave, m_duty}) begin
                     m_duty = m_pb[0]; m_slave = m_pb[1]; m_drv = m_pb[2];
                     m_lcd = 0; m_leden = 1; m_scan = 0;
                   end
            2'b01: begin m_tgt = m_pb[2:0]; m_fix = m_pb[3]; start = (m_pb[2:0] == 3'd4); end
            2'b10: m_addr = m_pb[4:0];
            default: {m_test, m_stby, m_scan, m_leden, m_lcd} = m_pb[5:0];
          endcase
        end else if (m_tgt == 3) begin
          m_led = m_pb[3:0];
        end else if (m_tgt <= 2 && m_addr <= lim(m_tgt) && !(m_tgt == 2 && m_pb[7:5] == 3'd7)) begin
          m_we = 1; m_wsel = m_tgt; m_waddr = m_addr; m_wdata = m_pb;
          if (!m_fix && m_tgt != 2) m_addr++;
        end
      end
      if (!stb) begin
        m_act = 0; m_cur = 1;
      end else if (start) begin
        m_act = 1; m_cur = 1; m_ph = 0; m_idx = 0;
      end else if (m_act && fall) begin
        if (m_ph == 0) m_osh = key_mem[m_idx];
        m_cur = m_osh[7];
        m_osh = m_osh << 1;
        m_ph = (m_ph + 1) % 8;
        if (m_ph == 0) m_idx = (m_idx + 1) % 4;
      end
      m_pv = 0;
      if (!stb) begin
        m_cnt = 0; m_first = 1;
      end else if (sck && !m_psck) begin
        m_sh = {m_sh[6:0], sdi};
        m_cnt++;
        if (m_cnt == 8) begin
          m_pv = 1; m_pb = m_sh; m_pc = m_first; m_first = 0; m_cnt = 0;
        end
      end
      m_psck = sck;
    end
  end

  // Compare against the model one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5 display mode", {duty_15, slave, drive_int}, {m_duty, m_slave, m_drv});
      chk("R4 status", {test_mode, standby, scan_en, led_en, lcd_mode},
          {m_test, m_stby, m_scan, m_leden, m_lcd});
      chk("R10 led latch", led_latch, m_led);
      chk("R6 write pulse", wr_en, m_we);
      if (m_we) chk("R6 write fields", {wr_sel, wr_addr, wr_data},
                    {m_wsel[1:0], m_waddr[4:0], m_wdata});
      chk("R11 data line", sdo_pull, m_act && stb && !m_cur);
      chk("R11 key index", key_idx, m_idx[1:0]);
    end
  end

  logic [14:0] wq[$];
  always @(posedge clk) if (rst_n && wr_en) wq.push_back({wr_sel, wr_addr, wr_data});

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sck = 1'b0; sdi = tx[i];
      tick(2);
      rx[i] = ~sdo_pull;
      sck = 1'b1;
      tick(2);
    end
  endtask

  task automatic put(input logic [7:0] b);
    logic [7:0] dummy;
    xfer(b, dummy);
  endtask

  task automatic part(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); sck = 1'b0; sdi = b[i];
      tick(2); sck = 1'b1; tick(2);
    end
  endtask

  task automatic open_f;
    @(negedge clk); stb = 1'b1; tick(2);
  endtask

  task automatic close_f;
    tick(2); stb = 1'b0; tick(4);
  endtask

  task automatic one(input logic [7:0] b);
    open_f; put(b); close_f;
  endtask

  task automatic chk_wq(input string tag, input int idx, input logic [14:0] exp);
    if (idx < wq.size()) chk(tag, wq[idx], exp);
    else chk(tag, 32'hDEAD, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    key_mem[0] = 8'hA5; key_mem[1] = 8'h3C; key_mem[2] = 8'h81; key_mem[3] = 8'h7E;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R12 reset state
    chk("R12 reset modes", {duty_15, slave, drive_int, lcd_mode, led_en, scan_en, standby, test_mode}, 0);
    chk("R12 reset led/key/line", {led_latch, key_idx, sdo_pull, wr_en}, 0);

    // R1 R3 R4: status commands, MSB first
    one(8'hCE);
    chk("R4 status CE", {test_mode, standby, scan_en, led_en, lcd_mode}, 6'b001110);
    chk("R1 msb first (reversed would be routing)", {lcd_mode, scan_en}, 3'b101);
    one(8'hF5);
    chk("R4 status F5", {test_mode, standby, scan_en, led_en, lcd_mode}, 6'b110101);

    // R5 display mode change and repeat
    one(8'hCE);
    one(8'h05);
    chk("R5 new display mode", {duty_15, slave, drive_int}, 3'b101);
    chk("R5 forced states", {lcd_mode, led_en, scan_en}, 4'b0010);
    one(8'hCE);
    one(8'h05);
    chk("R5 unchanged mode no effect", {lcd_mode, led_en, scan_en}, 4'b1011);

    // R3 R6 R7 R8 display RAM with increment up to the last location
    wq.delete();
    one(8'h40);
    chk("R3 routing leaves status", {lcd_mode, scan_en}, 3'b101);
    open_f; put(8'h96); put(8'hA1); put(8'hA2); put(8'hA3); put(8'hA4); close_f;
    chk("R8 writes stop past last", wq.size(), 3);
    chk_wq("R6 first write", 0, {2'd0, 5'd22, 8'hA1});
    chk_wq("R7 increment", 1, {2'd0, 5'd23, 8'hA2});
    chk_wq("R8 last location", 2, {2'd0, 5'd24, 8'hA3});

    // R7 R8 character RAM, fixed address, out-of-range address
    wq.delete();
    one(8'h49);
    open_f; put(8'h83); put(8'h11); put(8'h22); close_f;
    chk("R7 fixed count", wq.size(), 2);
    chk_wq("R7 fixed addr a", 0, {2'd1, 5'd3, 8'h11});
    chk_wq("R7 fixed addr b", 1, {2'd1, 5'd3, 8'h22});
    wq.delete();
    open_f; put(8'h89); put(8'h33); close_f;
    chk("R8 out of range blocked", wq.size(), 0);

    // R9 R7 generator RAM rows
    wq.delete();
    one(8'h42);
    open_f; put(8'h85); put(8'h1F); put(8'hE5); put(8'hC3); close_f;
    chk("R9 row 7 dropped", wq.size(), 2);
    chk_wq("R9 row 0", 0, {2'd2, 5'd5, 8'h1F});
    chk_wq("R7 code held", 1, {2'd2, 5'd5, 8'hC3});

    // R10 LED latch
    wq.delete();
    open_f; put(8'h43); put(8'hF9); close_f;
    chk("R10 low bits", led_latch, 4'h9);
    chk("R10 no write pulse", wq.size(), 0);

    // R2 strobe drop mid-byte
    wq.delete();
    one(8'h40);
    open_f; put(8'h80); put(8'h55); part(8'hFF, 4); stb = 1'b0; tick(4);
    chk("R2 partial data discarded", wq.size(), 1);
    chk_wq("R2 completed byte kept", 0, {2'd0, 5'd0, 8'h55});
    open_f; part(8'hC0, 4); stb = 1'b0; tick(4);
    chk("R2 partial command discarded", {lcd_mode, led_en, scan_en}, 4'b1011);
    one(8'hC0);
    chk("R2 next frame decodes command", {lcd_mode, led_en, scan_en}, 4'b0000);

    // R6 undefined target
    wq.delete();
    one(8'h47);
    open_f; put(8'h80); put(8'h12); close_f;
    chk("R6 undefined target ignored", wq.size(), 0);

    // R11 key readback with wrap
    open_f; put(8'h44);
    xfer(8'hFF, rb); chk("R11 key byte 0", rb, 8'hA5);
    xfer(8'hFF, rb); chk("R11 key byte 1", rb, 8'h3C);
    xfer(8'hFF, rb); chk("R11 key byte 2", rb, 8'h81);
    xfer(8'hFF, rb); chk("R11 key byte 3", rb, 8'h7E);
    xfer(8'hFF, rb); chk("R11 wrap to byte 0", rb, 8'hA5);
    close_f;
    chk("R11 line released", sdo_pull, 1'b0);

    tick(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule